// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller Register File

This block is the register file for an interrupt controller whose lines are all level-sensitive. It serves up to four banks of 32 lines each. It samples the raw lines, holds a pending bit for every line, and combines each pending bit with a per-bank mask, a software-raised interrupt word and a per-line route bit. The route bit chooses the normal (IRQ) path or the fast (FIQ) path. The block presents the resulting request vectors, together with every line's priority, to an attached arbitration core. It also returns that core's sorted winner codes to software.

Software reaches the block over a simple 32-bit bus: one access per cycle, with strobes `bus_sel` and `bus_wr`. Read data and the error flag are registered and appear one cycle after the access. There are three address regions:

- a global region for identification, configuration, control and idle setup;
- a per-bank region, eight words per bank;
- a per-line region of configuration words.

Top module: `lvint_regs`

## Requirements
- R1: Address 0x000 reads 0x21 and address 0x014 reads 1. Writes to these and to the other read-only words are ignored: the sorted codes, a bank's raw word (+0x00), and a bank's two pending views (+0x18, +0x1C).
- R2: Read data and the error flag are registered and valid in the cycle after the access. Any access to an unmapped or non-word-aligned address (addr[1:0] != 0) returns 0 and raises `bus_err` for exactly that one cycle.
- R3: Hardware reset and a write of 1 to bit 1 of 0x010 (soft reset) both restore the following state: every mask is 0xFFFFFFFF; pending, software, raw, route and priority state is 0; the global mask, idle field and auto-idle bit are 0.
- R4: Bank b occupies 0x080+0x20*b. Its mask word at +0x04 is written whole. A write to +0x08 clears the mask bits that are set in the data, and a write to +0x0C sets them. Both +0x08 and +0x0C read 0.
- R5: The raw word (+0x00) shows the line levels sampled at the previous clock edge. A line that rises sets its pending bit. When the line falls, the pending bit takes the value of that line's software bit.
- R6: A write to +0x10 ORs the data into the software word and into the pending bits. Reading +0x10 returns the software word.
- R7: A write to +0x14 clears the software bits named in the data, then sets pending to the new software word ANDed with the current line levels. A line that rises in the same cycle as this write stays pending.
- R8: The pending-IRQ view (+0x18) equals pending AND NOT mask AND NOT route. The pending-FIQ view (+0x1C) equals pending AND NOT mask AND route.
- R9: The configuration word for line l of bank b is at 0x100+0x80*b+4*l. Bits [7:2] hold the 6-bit priority and bit 0 holds the route (1 = FIQ). Bit 1 reads 0.
- R10: `irq_req` and `fiq_req` equal the two pending views, except that both are forced to 0 while the global mask (bit 2 of 0x048) is set. Reads of 0x048 return only the global mask, in bit 2.
- R11: Writing 0x048 with bit 0 set produces a one-cycle pulse on `irq_agr`. Bit 1 produces a one-cycle pulse on `fiq_agr`.
- R12: 0x040 and 0x044 return `arb_irq_code` and `arb_fiq_code`, zero-extended. 0x050 holds a 2-bit idle field. Bit 0 of 0x010 holds the auto-idle bit, which reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Unmapped-access flag, one cycle after the access |
| irq_lines | input | NBANKS*32 | Level interrupt lines |
| arb_irq_code | input | CW | Sorted IRQ winner from the arbiter |
| arb_fiq_code | input | CW | Sorted FIQ winner from the arbiter |
| irq_req | output | NBANKS*32 | Requests routed to IRQ, gated by the global mask |
| fiq_req | output | NBANKS*32 | Requests routed to FIQ, gated by the global mask |
| line_prio | output | NBANKS*32*PW | Priority of every line, packed by line index |
| irq_agr | output | 1 | New-IRQ-agreement pulse |
| fiq_agr | output | 1 | New-FIQ-agreement pulse |

## Verification
A software-clear write and a rising edge on a line of the same bank can land on the same clock edge. The clear rebuilds the whole pending word from the software bits and the current levels, while the edge tries to set one bit. The bench drives both on the same clock edge: it raises one line while clearing the software bits of that line and of a second line that is already high. It then requires the pending-IRQ view to keep only the rising line. The raw word must still show both lines high.

// File: rtl/lvint_pkg.sv
package lvint_pkg;

  localparam int REG_W = 32;
  localparam logic [REG_W-1:0] REV_VALUE = 32'h0000_0021;

  typedef enum logic [2:0] {
    GR_REV, GR_CFG, GR_STAT, GR_SIRQ, GR_SFIQ, GR_CTRL, GR_IDLE, GR_NONE
  } glob_reg_e;

  // Encoding equals word index inside a bank window.
  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_SSET = 3'd4,
    BR_SCLR = 3'd5,
    BR_PIRQ = 3'd6,
    BR_PFIQ = 3'd7
  } bank_reg_e;

  typedef struct packed {
    logic      glob_hit;
    glob_reg_e greg;
    logic      bank_hit;
    logic [1:0] bank;
    bank_reg_e breg;
    logic      line_hit;
    logic [1:0] lbank;
    logic [4:0] line;
  } dec_t;

  // Pending view for one path.
  function automatic logic [REG_W-1:0] f_view(input logic [REG_W-1:0] pend,
                                              input logic [REG_W-1:0] mask,
                                              input logic [REG_W-1:0] route,
                                              input logic want_fiq);
    return pend & ~mask & (want_fiq ? route : ~route);
  endfunction

  function automatic logic [REG_W-1:0] f_mask_next(input logic [REG_W-1:0] mask,
                                                   input logic we,
                                                   input bank_reg_e breg,
                                                   input logic [REG_W-1:0] wdata);
    logic [REG_W-1:0] m;
    m = mask;
    if (we) begin
      case (breg)
        BR_MASK: m = wdata;
        BR_MCLR: m = mask & ~wdata;
        BR_MSET: m = mask | wdata;
        default: m = mask;
      endcase
    end
    return m;
  endfunction

  // Next pending word: edges, software set, software clear rebuild.
  function automatic logic [REG_W-1:0] f_pend_next(input logic [REG_W-1:0] pend,
                                                   input logic [REG_W-1:0] rise,
                                                   input logic [REG_W-1:0] fall,
                                                   input logic [REG_W-1:0] swi_n,
                                                   input logic [REG_W-1:0] lvl,
                                                   input logic sset,
                                                   input logic sclr,
                                                   input logic [REG_W-1:0] wdata);
    logic [REG_W-1:0] p;
    p = ((pend | rise) & ~fall) | (fall & swi_n);
    if (sset) p = p | wdata;
    if (sclr) p = (swi_n & lvl) | rise;
    return p;
  endfunction

endpackage

// File: rtl/lvint_decode.sv
module lvint_decode
  import lvint_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NBANKS = 4
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  localparam int GLOB_END  = 128;
  localparam int BANK_END  = 256;
  localparam int LINE_BASE = 256;
  localparam int LINE_END  = LINE_BASE + 128 * NBANKS;

  logic [8:0] off;
  assign off = 9'(addr - AW'(LINE_BASE));

  always_comb begin
    dec      = '0;
    dec.greg = GR_NONE;
    dec.breg = BR_RAW;
    if (addr[1:0] == 2'b00) begin
      if (addr < AW'(GLOB_END)) begin
        dec.glob_hit = 1'b1;
        case (addr[6:0])
          7'h00:   dec.greg = GR_REV;
          7'h10:   dec.greg = GR_CFG;
          7'h14:   dec.greg = GR_STAT;
          7'h40:   dec.greg = GR_SIRQ;
          7'h44:   dec.greg = GR_SFIQ;
          7'h48:   dec.greg = GR_CTRL;
          7'h50:   dec.greg = GR_IDLE;
          default: dec.glob_hit = 1'b0;
        endcase
      end else if (addr < AW'(BANK_END)) begin
        if (int'(addr[6:5]) < NBANKS) begin
          dec.bank_hit = 1'b1;
          dec.bank     = addr[6:5];
          dec.breg     = bank_reg_e'(addr[4:2]);
        end
      end else if (addr < AW'(LINE_END)) begin
        dec.line_hit = 1'b1;
        dec.lbank    = off[8:7];
        dec.line     = off[6:2];
      end
    end
  end
endmodule

// File: rtl/lvint_global.sv
module lvint_global
  import lvint_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  glob_reg_e        greg,
  input  logic [2:0]       wbits,
  input  logic [CW-1:0]    irq_code,
  input  logic [CW-1:0]    fiq_code,
  output logic             srst,
  output logic             gmask,
  output logic             irq_agr,
  output logic             fiq_agr,
  output logic [REG_W-1:0] rdata
);
  logic       autoidle_q;
  logic [1:0] idle_q;

  assign srst = we && (greg == GR_CFG) && wbits[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autoidle_q <= 1'b0;
      idle_q     <= 2'b00;
      gmask      <= 1'b0;
      irq_agr    <= 1'b0;
      fiq_agr    <= 1'b0;
    end else begin
      irq_agr <= we && (greg == GR_CTRL) && wbits[0];
      fiq_agr <= we && (greg == GR_CTRL) && wbits[1];
      if (srst) begin
        autoidle_q <= 1'b0;
        idle_q     <= 2'b00;
        gmask      <= 1'b0;
      end else if (we) begin
        case (greg)
          GR_CFG:  autoidle_q <= wbits[0];
          GR_CTRL: gmask      <= wbits[2];
          GR_IDLE: idle_q     <= wbits[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (greg)
      GR_REV:  rdata = REV_VALUE;
      GR_CFG:  rdata = REG_W'(autoidle_q);
      GR_STAT: rdata = REG_W'(1);
      GR_SIRQ: rdata = REG_W'(irq_code);
      GR_SFIQ: rdata = REG_W'(fiq_code);
      GR_CTRL: rdata = REG_W'({gmask, 2'b00});
      GR_IDLE: rdata = REG_W'(idle_q);
      default: rdata = '0;
    endcase
  end

  // R11: an agreement pulse only follows a bus write
  p_agr_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_agr |-> $past(we));
  p_agr_fiq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_agr |-> $past(we));
  // R10: global mask changes only on a write
  p_gmask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(gmask));
endmodule

// File: rtl/lvint_bank.sv
module lvint_bank
  import lvint_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst,
  input  logic                we,
  input  bank_reg_e           breg,
  input  logic [REG_W-1:0]    wdata,
  input  logic                cfg_we,
  input  logic [4:0]          cfg_line,
  input  logic [REG_W-1:0]    lvl,
  output logic [REG_W-1:0]    mask,
  output logic [REG_W-1:0]    pend,
  output logic [REG_W-1:0]    route,
  output logic [REG_W*PW-1:0] prio_flat,
  output logic [REG_W-1:0]    rdata
);
  logic [REG_W-1:0] raw_q, swi_q, swi_n, rise, fall;
  logic sset, sclr;

  assign rise = lvl & ~raw_q;
  assign fall = ~lvl & raw_q;
  assign sset = we && (breg == BR_SSET);
  assign sclr = we && (breg == BR_SCLR);

  always_comb begin
    swi_n = swi_q;
    if (sset) swi_n = swi_q | wdata;
    if (sclr) swi_n = swi_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      mask  <= '1;
      swi_q <= '0;
      pend  <= '0;
    end else if (srst) begin
      raw_q <= '0;
      mask  <= '1;
      swi_q <= '0;
      pend  <= '0;
    end else begin
      raw_q <= lvl;
      mask  <= f_mask_next(mask, we, breg, wdata);
      swi_q <= swi_n;
      pend  <= f_pend_next(pend, rise, fall, swi_n, lvl, sset, sclr, wdata);
    end
  end

  for (genvar l = 0; l < REG_W; l++) begin : g_line
    logic [PW-1:0] prio_r;
    logic          route_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_r  <= '0;
        route_r <= 1'b0;
      end else if (srst) begin
        prio_r  <= '0;
        route_r <= 1'b0;
      end else if (cfg_we && (cfg_line == 5'(l))) begin
        prio_r  <= wdata[2 +: PW];
        route_r <= wdata[0];
      end
    end
    assign prio_flat[l*PW +: PW] = prio_r;
    assign route[l]              = route_r;
  end

  always_comb begin
    case (breg)
      BR_RAW:  rdata = raw_q;
      BR_MASK: rdata = mask;
      BR_SSET: rdata = swi_q;
      BR_PIRQ: rdata = f_view(pend, mask, route, 1'b0);
      BR_PFIQ: rdata = f_view(pend, mask, route, 1'b1);
      default: rdata = '0;
    endcase
  end

  // R4: cleared mask bits are zero afterwards
  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && breg == BR_MCLR) |=> ((mask & $past(wdata)) == '0));
  // R6: software set lands in pending
  p_swset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && breg == BR_SSET) |=> ((pend & $past(wdata)) == $past(wdata)));
  // R5: a rising line is pending one edge later
  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> ((pend & $past(rise)) == $past(rise)));
  // R3: soft reset restores the bank
  p_srst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (mask == '1 && swi_q == '0 && pend == '0 && route == '0));
endmodule

// File: rtl/lvint_regs.sv
module lvint_regs
  import lvint_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NBANKS = 4,
  parameter int PW     = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [AW-1:0]               bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_err,
  input  logic [NBANKS*32-1:0]        irq_lines,
  input  logic [$clog2(NBANKS*32)-1:0] arb_irq_code,
  input  logic [$clog2(NBANKS*32)-1:0] arb_fiq_code,
  output logic [NBANKS*32-1:0]        irq_req,
  output logic [NBANKS*32-1:0]        fiq_req,
  output logic [NBANKS*32*PW-1:0]     line_prio,
  output logic                        irq_agr,
  output logic                        fiq_agr
);
  localparam int LPB    = REG_W;
  localparam int NLINES = NBANKS * LPB;
  localparam int CW     = $clog2(NLINES);

  dec_t dec;
  logic acc_wr, srst, gmask;
  logic [REG_W-1:0] g_rdata, rd_next;
  logic err_next;

  logic [LPB-1:0]    b_mask  [NBANKS];
  logic [LPB-1:0]    b_pend  [NBANKS];
  logic [LPB-1:0]    b_route [NBANKS];
  logic [LPB-1:0]    b_rdata [NBANKS];
  logic [LPB*PW-1:0] b_prio  [NBANKS];

  assign acc_wr = bus_sel && bus_wr;

  lvint_decode #(.AW(AW), .NBANKS(NBANKS)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  lvint_global #(.CW(CW)) u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (acc_wr && dec.glob_hit),
    .greg     (dec.greg),
    .wbits    (bus_wdata[2:0]),
    .irq_code (arb_irq_code),
    .fiq_code (arb_fiq_code),
    .srst     (srst),
    .gmask    (gmask),
    .irq_agr  (irq_agr),
    .fiq_agr  (fiq_agr),
    .rdata    (g_rdata)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    lvint_bank #(.PW(PW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (srst),
      .we        (acc_wr && dec.bank_hit && (dec.bank == 2'(b))),
      .breg      (dec.breg),
      .wdata     (bus_wdata),
      .cfg_we    (acc_wr && dec.line_hit && (dec.lbank == 2'(b))),
      .cfg_line  (dec.line),
      .lvl       (irq_lines[b*LPB +: LPB]),
      .mask      (b_mask[b]),
      .pend      (b_pend[b]),
      .route     (b_route[b]),
      .prio_flat (b_prio[b]),
      .rdata     (b_rdata[b])
    );
    assign irq_req[b*LPB +: LPB] = gmask ? '0 : f_view(b_pend[b], b_mask[b], b_route[b], 1'b0);
    assign fiq_req[b*LPB +: LPB] = gmask ? '0 : f_view(b_pend[b], b_mask[b], b_route[b], 1'b1);
    assign line_prio[b*LPB*PW +: LPB*PW] = b_prio[b];
  end

  always_comb begin
    rd_next  = '0;
    err_next = bus_sel && !(dec.glob_hit || dec.bank_hit || dec.line_hit);
    if (dec.glob_hit) begin
      rd_next = g_rdata;
    end else if (dec.bank_hit) begin
      rd_next = b_rdata[dec.bank];
    end else if (dec.line_hit) begin
      rd_next[2 +: PW] = b_prio[dec.lbank][dec.line*PW +: PW];
      rd_next[0]       = b_route[dec.lbank][dec.line];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_sel && !bus_wr && !err_next) ? rd_next : '0;
      bus_err   <= err_next;
    end
  end

  // R2: error only after an access, and with zero data
  p_err_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));
  p_err_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));
  // R8: a line never requests both paths
  p_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & fiq_req) == '0);
  // R10: global mask silences both request vectors
  p_gmask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |-> (irq_req == '0 && fiq_req == '0));
endmodule

// File: tb/tb_lvint_regs.sv
module tb_lvint_regs;
  localparam int AW = 12;
  localparam int NB = 4;
  localparam int PW = 6;
  localparam int NL = NB * 32;
  localparam int CW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_err;
  logic [NL-1:0]   irq_lines = '0;
  logic [CW-1:0]   arb_irq_code = '0, arb_fiq_code = '0;
  logic [NL-1:0]   irq_req, fiq_req;
  logic [NL*PW-1:0] line_prio;
  logic            irq_agr, fiq_agr;

  lvint_regs #(.AW(AW), .NBANKS(NB), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_lines(irq_lines), .arb_irq_code(arb_irq_code),
    .arb_fiq_code(arb_fiq_code), .irq_req(irq_req), .fiq_req(fiq_req),
    .line_prio(line_prio), .irq_agr(irq_agr), .fiq_agr(fiq_agr)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input logic ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] rd; logic er;
    acc(1'b0, a, 32'h0, rd, er);
    chk(rd == exp && !er, tag, 128'(rd), 128'(exp));
  endtask

  task automatic wr_do(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    acc(1'b1, a, d, rd, er);
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,        32'h21,       1'b0, 4'd1},  // R1
    '{1'b0, 12'h014, 32'h0,        32'h1,        1'b0, 4'd1},  // R1
    '{1'b1, 12'h000, 32'hFFFF,     32'h0,        1'b0, 4'd1},  // R1
    '{1'b0, 12'h000, 32'h0,        32'h21,       1'b0, 4'd1},  // R1
    '{1'b0, 12'h084, 32'h0,        32'hFFFFFFFF, 1'b0, 4'd3},  // R3
    '{1'b0, 12'h0E4, 32'h0,        32'hFFFFFFFF, 1'b0, 4'd3},  // R3
    '{1'b1, 12'h084, 32'h0000FFFF, 32'h0,        1'b0, 4'd4},  // R4
    '{1'b1, 12'h088, 32'h000000F0, 32'h0,        1'b0, 4'd4},  // R4
    '{1'b0, 12'h084, 32'h0,        32'h0000FF0F, 1'b0, 4'd4},  // R4
    '{1'b1, 12'h08C, 32'h80000000, 32'h0,        1'b0, 4'd4},  // R4
    '{1'b0, 12'h084, 32'h0,        32'h8000FF0F, 1'b0, 4'd4},  // R4
    '{1'b0, 12'h088, 32'h0,        32'h0,        1'b0, 4'd4},  // R4
    '{1'b1, 12'h090, 32'h00000011, 32'h0,        1'b0, 4'd6},  // R6
    '{1'b0, 12'h090, 32'h0,        32'h11,       1'b0, 4'd6},  // R6
    '{1'b0, 12'h098, 32'h0,        32'h10,       1'b0, 4'd8},  // R8
    '{1'b1, 12'h110, 32'h000000FF, 32'h0,        1'b0, 4'd9},  // R9
    '{1'b0, 12'h110, 32'h0,        32'hFD,       1'b0, 4'd9},  // R9
    '{1'b0, 12'h098, 32'h0,        32'h0,        1'b0, 4'd8},  // R8
    '{1'b0, 12'h09C, 32'h0,        32'h10,       1'b0, 4'd8},  // R8
    '{1'b1, 12'h09C, 32'h0,        32'h0,        1'b0, 4'd1},  // R1
    '{1'b0, 12'h09C, 32'h0,        32'h10,       1'b0, 4'd1},  // R1
    '{1'b1, 12'h094, 32'h00000010, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b0, 12'h090, 32'h0,        32'h01,       1'b0, 4'd7},  // R7
    '{1'b0, 12'h09C, 32'h0,        32'h0,        1'b0, 4'd7},  // R7
    '{1'b1, 12'h050, 32'hFF,       32'h0,        1'b0, 4'd12}, // R12
    '{1'b0, 12'h050, 32'h0,        32'h3,        1'b0, 4'd12}, // R12
    '{1'b1, 12'h010, 32'h1,        32'h0,        1'b0, 4'd12}, // R12
    '{1'b0, 12'h010, 32'h0,        32'h1,        1'b0, 4'd12}, // R12
    '{1'b0, 12'h020, 32'h0,        32'h0,        1'b1, 4'd2},  // R2
    '{1'b0, 12'h300, 32'h0,        32'h0,        1'b1, 4'd2},  // R2
    '{1'b0, 12'h002, 32'h0,        32'h0,        1'b1, 4'd2},  // R2
    '{1'b0, 12'h2FC, 32'h0,        32'h0,        1'b0, 4'd9},  // R9
    '{1'b1, 12'h184, 32'h0000000E, 32'h0,        1'b0, 4'd9},  // R9
    '{1'b0, 12'h184, 32'h0,        32'h0C,       1'b0, 4'd9}   // R9
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd; logic er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: reset state at the ports
    chk(bus_rdata == 0 && bus_err == 0, "R3 bus idle", 128'({bus_err, bus_rdata}), 128'(0));
    chk(irq_req == 0 && fiq_req == 0, "R3 no requests", 128'(irq_req | fiq_req), 128'(0));
    chk(irq_agr == 0 && fiq_agr == 0, "R3 no pulses", 128'({irq_agr, fiq_agr}), 128'(0));

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, er);
      n_chk++;
      if (rd !== VECS[i].exp || er !== VECS[i].exp_err) begin
        n_bad++;
        $display("FAIL R%0d vector %0d addr=%h actual=%h/%b expected=%h/%b",
                 VECS[i].req, i, VECS[i].addr, rd, er, VECS[i].exp, VECS[i].exp_err);
      end
    end

    // R5: level behaviour, bank 0 fully unmasked (line 4 routed to FIQ)
    wr_do(12'h088, 32'hFFFFFFFF);
    irq_lines[2] = 1'b1;
    rd_chk(12'h080, 32'h4, "R5 raw word");
    rd_chk(12'h098, 32'h4, "R5 rise sets pending");
    irq_lines[2] = 1'b0;
    rd_chk(12'h098, 32'h0, "R5 fall takes software bit 0");
    irq_lines[0] = 1'b1;
    rd_chk(12'h098, 32'h1, "R5 rise line0");
    irq_lines[0] = 1'b0;
    rd_chk(12'h098, 32'h1, "R5 fall takes software bit 1");

    // R10 / R8: request outputs
    chk(irq_req[31:0] == 32'h1, "R10 irq_req view", 128'(irq_req), 128'(1));
    irq_lines[4] = 1'b1;
    @(negedge clk);
    chk(fiq_req[31:0] == 32'h10 && irq_req[31:0] == 32'h1, "R8 split by route",
        128'({fiq_req[31:0], irq_req[31:0]}), 128'({32'h10, 32'h1}));
    irq_lines[4] = 1'b0;
    wr_do(12'h048, 32'h4);
    chk(irq_req == 0 && fiq_req == 0, "R10 global mask", 128'(irq_req), 128'(0));
    rd_chk(12'h048, 32'h4, "R10 control readback");
    wr_do(12'h048, 32'h0);
    chk(irq_req[31:0] == 32'h1, "R10 unmask restores", 128'(irq_req), 128'(1));

    // R11: agreement pulses
    wr_do(12'h048, 32'h1);
    chk(irq_agr == 1 && fiq_agr == 0, "R11 irq pulse", 128'({irq_agr, fiq_agr}), 128'(2'b10));
    @(negedge clk);
    chk(irq_agr == 0, "R11 irq pulse width", 128'(irq_agr), 128'(0));
    wr_do(12'h048, 32'h2);
    chk(fiq_agr == 1 && irq_agr == 0, "R11 fiq pulse", 128'({irq_agr, fiq_agr}), 128'(2'b01));
    @(negedge clk);
    chk(fiq_agr == 0, "R11 fiq pulse width", 128'(fiq_agr), 128'(0));

    // R12: sorted codes from the arbiter
    arb_irq_code = 7'h5A; arb_fiq_code = 7'h13;
    rd_chk(12'h040, 32'h5A, "R12 irq code");
    rd_chk(12'h044, 32'h13, "R12 fiq code");

    // R7: software clear in the same cycle as a rising line
    irq_lines[5] = 1'b1;
    rd_chk(12'h080, 32'h20, "R7 line5 high");
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h094; bus_wdata = 32'h28;
    irq_lines[3] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd_chk(12'h098, 32'h8, "R7 collision keeps rising line only");
    rd_chk(12'h080, 32'h28, "R7 raw unaffected");

    // R5: another bank
    irq_lines[64+7] = 1'b1;
    rd_chk(12'h0C0, 32'h80, "R5 bank2 raw");

    // R3: soft reset
    wr_do(12'h010, 32'h2);
    rd_chk(12'h084, 32'hFFFFFFFF, "R3 soft reset mask");
    rd_chk(12'h090, 32'h0, "R3 soft reset software word");
    rd_chk(12'h110, 32'h0, "R3 soft reset line config");
    rd_chk(12'h050, 32'h0, "R3 soft reset idle");
    rd_chk(12'h010, 32'h0, "R3 soft reset autoidle");
    chk(irq_req == 0 && fiq_req == 0, "R3 soft reset requests", 128'(irq_req), 128'(0));

    finish_run();
  end
endmodule